// File: doc/BRIEF.md
# Framebuffer Display Controller Register and Interrupt Bank

This block is the software-visible register set of a framebuffer display controller. A host reaches it over a plain 32-bit bus made of a byte address, a write strobe, write data and combinational read data. Writes land on the rising clock edge. Reads return the addressed register in the same cycle. The bank holds five control words, three framebuffer address words, three colour lookup words, a dither word and a temporary palette word. It also holds an interrupt pending register, a source pending register, an interrupt mask register, a panel-select word, and a 256-entry window of 16-bit palette entries.

The bank decodes the fields that the display engine needs: display enable, pixel mode, 565 colour format, byte order and the framebuffer base address. It also raises an interrupt line. The display engine reports the end of each frame on `frame_sync`. That pulse marks the frame source as pending, and the bank then folds the unmasked source bits into the pending bits. The same fold happens whenever the host writes the mask.

Top module: `lcdc_csr_bank`

## Requirements
- R1: After reset, every register except the palette reads zero, the interrupt mask reads 3, the panel-select word reads 4, and `irq` is low.
- R2: The words at 0x04, 0x08, 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28, 0x4C and 0x50 store and return all 32 written bits. The two low address bits are ignored when a register is decoded.
- R3: Writes are masked: 0x00 keeps bits [17:0], 0x0C keeps [15:0], 0x10 keeps [12:0], pending (0x54) and source pending (0x58) keep [1:0], and the mask (0x5C) keeps [2:0].
- R4: A write of value v to panel select (0x60) stores (v & 3) | 4, so read bit 2 is always one and bits [31:3] are zero.
- R5: Byte offsets 0x400 to 0x5FF address palette entry (offset - 0x400) >> 1. The entry stores the low 16 bits of the write, and a read returns it zero-extended.
- R6: A read of any offset below 0x400 that is not listed in R2 to R4 returns zero. A write there changes no register.
- R7: `disp_en` follows bit 0 of 0x00, `pix_mode` follows bits [4:1] of 0x00, `fmt565` follows bit 11 of 0x10, and `byte_swap` follows bit 12 of 0x10.
- R8: `fb_base` equals the 0x14 word shifted left by one, with bit 0 and bit 31 zero.
- R9: A `frame_sync` pulse sets source pending bit 1. In the same edge, pending becomes pending | (source & ~mask[1:0]).
- R10: A mask write performs the same fold, pending |= source & ~new_mask[1:0]. No other event sets pending bits.
- R11: A write to pending or to source pending replaces the stored value: writing zero clears it, and writing to source pending does not fold into pending.
- R12: `irq` is high exactly when any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (11) | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_sync | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Interrupt request |
| disp_en | output | 1 | Display enable |
| pix_mode | output | 4 | Pixel mode field |
| fmt565 | output | 1 | 565 colour format select |
| byte_swap | output | 1 | Byte order select |
| fb_base | output | 32 | Framebuffer base byte address |

## Verification
The hardest state to reach is a pending bit set by the fold rather than by a direct write. That state exists only when a source bit is present, the mask leaves it unmasked, and a mask write or a frame pulse follows. The bench reaches it in two ways. First, it sweeps every mask value against every source value: it clears pending, loads source pending, and then writes the mask. Second, for every mask value it clears both pending registers and pulses `frame_sync`. In each case it compares pending, source pending and `irq` with values it computes itself.

// File: rtl/lcdc_csr_pkg.sv
// Shared constants, decode kinds and per-register write masks for the
// display controller register bank. Assumes byte addressing, 32-bit words.
package lcdc_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int PAL_W     = 16;
    localparam int NUM_PLAIN = 13;   // control x5, address x3, lut x3, dither, tpal
    localparam int PLAIN_IDX_W = $clog2(NUM_PLAIN);
    localparam int IDX_CTRL1 = 0;
    localparam int IDX_CTRL5 = 4;
    localparam int IDX_SADDR1 = 5;
    localparam int OFF_IPND  = 'h54;
    localparam int OFF_SPND  = 'h58;
    localparam int OFF_IMSK  = 'h5C;
    localparam int OFF_PANEL = 'h60;
    localparam logic [2:0] IMSK_RST = 3'b011;

    typedef enum logic [2:0] {
        K_NONE, K_PLAIN, K_IPND, K_SPND, K_IMSK, K_PANEL, K_PAL
    } kind_e;

    // Byte offset of plain register i.
    function automatic int plain_offset(int i);
        if (i < 11)       return i * 4;
        else if (i == 11) return 'h4C;
        else              return 'h50;
    endfunction

    // Bits retained on a write to plain register i.
    function automatic logic [DATA_W-1:0] plain_mask(int i);
        case (i)
            0:       return 32'h0003_FFFF;
            3:       return 32'h0000_FFFF;
            4:       return 32'h0000_1FFF;
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/lcdc_csr_decode.sv
// Address decoder: classifies a byte address as a plain register, one of the
// interrupt/panel registers, a palette entry, or unmapped.
// Assumes the palette window is the range whose top two address bits are 2'b10.
module lcdc_csr_decode
    import lcdc_csr_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAL_IDX_W = ADDR_W - 3
) (
    input  logic [ADDR_W-1:0]      addr,
    output kind_e                  kind,
    output logic [PLAIN_IDX_W-1:0] plain_idx,
    output logic [PAL_IDX_W-1:0]   pal_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;

    assign word       = addr[ADDR_W-1:2];
    assign pal_idx    = addr[PAL_IDX_W:1];
    assign unused_lsb = addr[0];

    // Pick the register class for the current address.
    always_comb begin
        kind      = K_NONE;
        plain_idx = '0;
        if (addr[ADDR_W-1 -: 2] == 2'b10) begin
            kind = K_PAL;
        end else begin
            for (int i = 0; i < NUM_PLAIN; i++) begin
                if (word == WORD_W'(plain_offset(i) >> 2)) begin
                    kind      = K_PLAIN;
                    plain_idx = PLAIN_IDX_W'(i);
                end
            end
            if (word == WORD_W'(OFF_IPND >> 2))  kind = K_IPND;
            if (word == WORD_W'(OFF_SPND >> 2))  kind = K_SPND;
            if (word == WORD_W'(OFF_IMSK >> 2))  kind = K_IMSK;
            if (word == WORD_W'(OFF_PANEL >> 2)) kind = K_PANEL;
        end
    end
endmodule

// File: rtl/lcdc_irq_ctrl.sv
// Interrupt pending, source pending and mask registers with the fold
// pending |= source & ~mask on a mask write or a frame-sync pulse.
// Assumes a frame pulse and a source write in one cycle: the pulse wins bit 1.
module lcdc_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_ipnd,
    input  logic       we_spnd,
    input  logic       we_imsk,
    input  logic [2:0] wdata,
    input  logic       frame_sync,
    output logic [1:0] ipnd_q,
    output logic [1:0] spnd_q,
    output logic [2:0] imsk_q,
    output logic       irq
);
    logic [1:0] ipnd_n, spnd_n;
    logic [2:0] imsk_n;

    // Next-state of the three registers, including the fold.
    always_comb begin
        spnd_n = we_spnd ? wdata[1:0] : spnd_q;
        if (frame_sync) spnd_n[1] = 1'b1;
        imsk_n = we_imsk ? wdata : imsk_q;
        ipnd_n = we_ipnd ? wdata[1:0] : ipnd_q;
        if (we_imsk || frame_sync) ipnd_n = ipnd_n | (spnd_n & ~imsk_n[1:0]);
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipnd_q <= '0;
            spnd_q <= '0;
            imsk_q <= IMSK_RST_L;
        end else begin
            ipnd_q <= ipnd_n;
            spnd_q <= spnd_n;
            imsk_q <= imsk_n;
        end
    end

    localparam logic [2:0] IMSK_RST_L = lcdc_csr_pkg::IMSK_RST;

    assign irq = |ipnd_q;
endmodule

// File: rtl/lcdc_palette_mem.sv
// Palette storage: DEPTH entries of WIDTH bits, synchronous write, async read.
// Assumes no reset of the contents.
module lcdc_palette_mem #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one entry per write.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/lcdc_csr_bank.sv
// Top of the register bank: plain registers with per-register write masks,
// panel select with a forced bit, interrupt block, palette and read mux.
// Assumes one bus access per cycle; reads are combinational.
module lcdc_csr_bank
    import lcdc_csr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_sync,
    output logic              irq,
    output logic              disp_en,
    output logic [3:0]        pix_mode,
    output logic              fmt565,
    output logic              byte_swap,
    output logic [31:0]       fb_base
);
    localparam int PAL_IDX_W = ADDR_W - 3;
    localparam int PAL_DEPTH = 1 << PAL_IDX_W;

    kind_e                  kind;
    logic [PLAIN_IDX_W-1:0] plain_idx;
    logic [PAL_IDX_W-1:0]   pal_idx;
    logic [DATA_W-1:0]      plain_q [NUM_PLAIN];
    logic [1:0]             panel_q;
    logic [1:0]             ipnd_q, spnd_q;
    logic [2:0]             imsk_q;
    logic [PAL_W-1:0]       pal_rd;

    lcdc_csr_decode #(.ADDR_W(ADDR_W), .PAL_IDX_W(PAL_IDX_W)) u_dec (
        .addr(bus_addr), .kind(kind), .plain_idx(plain_idx), .pal_idx(pal_idx)
    );

    lcdc_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .we_ipnd(bus_we && kind == K_IPND),
        .we_spnd(bus_we && kind == K_SPND),
        .we_imsk(bus_we && kind == K_IMSK),
        .wdata(bus_wdata[2:0]), .frame_sync(frame_sync),
        .ipnd_q(ipnd_q), .spnd_q(spnd_q), .imsk_q(imsk_q), .irq(irq)
    );

    lcdc_palette_mem #(.DEPTH(PAL_DEPTH), .WIDTH(PAL_W)) u_pal (
        .clk(clk), .we(bus_we && kind == K_PAL), .idx(pal_idx),
        .wdata(bus_wdata[PAL_W-1:0]), .rdata(pal_rd)
    );

    // Plain registers: masked store on an address match.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PLAIN; i++) begin
            if (!rst_n) plain_q[i] <= '0;
            else if (bus_we && kind == K_PLAIN && plain_idx == PLAIN_IDX_W'(i))
                plain_q[i] <= bus_wdata & plain_mask(i);
        end
    end

    // Panel select: two writable bits; bit 2 is supplied on read.
    always_ff @(posedge clk) begin
        if (!rst_n) panel_q <= '0;
        else if (bus_we && kind == K_PANEL) panel_q <= bus_wdata[1:0];
    end

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            K_PLAIN: bus_rdata = plain_q[plain_idx];
            K_IPND:  bus_rdata = {30'b0, ipnd_q};
            K_SPND:  bus_rdata = {30'b0, spnd_q};
            K_IMSK:  bus_rdata = {29'b0, imsk_q};
            K_PANEL: bus_rdata = {29'b0, 1'b1, panel_q};
            K_PAL:   bus_rdata = {{(DATA_W-PAL_W){1'b0}}, pal_rd};
            default: bus_rdata = '0;
        endcase
    end

    assign disp_en   = plain_q[IDX_CTRL1][0];
    assign pix_mode  = plain_q[IDX_CTRL1][4:1];
    assign fmt565    = plain_q[IDX_CTRL5][11];
    assign byte_swap = plain_q[IDX_CTRL5][12];
    assign fb_base   = {1'b0, plain_q[IDX_SADDR1][29:0], 1'b0};
endmodule

// File: rtl/lcdc_csr_bank_chk.sv
// Checker for lcdc_csr_bank: temporal properties on ports and the interrupt
// registers. Attached by bind below.
module lcdc_csr_bank_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              frame_sync,
    input logic              irq,
    input logic [31:0]       fb_base,
    input logic [1:0]        ipnd_q,
    input logic [1:0]        spnd_q,
    input logic [2:0]        imsk_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imsk_q == 3'd3 && ipnd_q == 2'd0 && spnd_q == 2'd0 && !irq));
    // R4
    panel_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h60 >> 2)) |-> (bus_rdata[31:2] == 30'd1));
    // R8
    fb_base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_base[0] && !fb_base[31]);
    // R9
    frame_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !(bus_we && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h58 >> 2))) |=> spnd_q[1]);
    // R10
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((ipnd_q & $past(ipnd_q)) == $past(ipnd_q)));
    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_sync || bus_we));
endmodule

bind lcdc_csr_bank lcdc_csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .frame_sync(frame_sync), .irq(irq),
    .fb_base(fb_base), .ipnd_q(ipnd_q), .spnd_q(spnd_q), .imsk_q(imsk_q)
);

// File: tb/lcdc_csr_bank_tb.sv
module lcdc_csr_bank_tb;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              frame_sync = 1'b0;
    logic              irq, disp_en, fmt565, byte_swap;
    logic [3:0]        pix_mode;
    logic [31:0]       fb_base;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    lcdc_csr_bank #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_sync(frame_sync),
        .irq(irq), .disp_en(disp_en), .pix_mode(pix_mode), .fmt565(fmt565),
        .byte_swap(byte_swap), .fb_base(fb_base)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
    endtask

    function automatic int offs(int i);
        if (i < 11) return i * 4;
        return (i == 11) ? 'h4C : 'h50;
    endfunction

    function automatic logic [31:0] msk(int i);
        if (i == 0) return 32'h0003_FFFF;
        if (i == 3) return 32'h0000_FFFF;
        if (i == 4) return 32'h0000_1FFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit mapped_word(int w);
        return (w <= 10) || (w >= 19 && w <= 24);
    endfunction

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [3];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5C3_5A3C; pats[2] = 32'h0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 13; i++) begin rd(offs(i), v); chk("R1 plain", v, 0); end
        rd('h54, v); chk("R1 ipnd", v, 0);
        rd('h58, v); chk("R1 spnd", v, 0);
        rd('h5C, v); chk("R1 imsk", v, 3);
        rd('h60, v); chk("R1 panel", v, 4);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 / R3: masked store across all plain registers and patterns
        foreach (pats[p]) begin
            for (int i = 0; i < 13; i++) wr(offs(i), pats[p] ^ (32'h0101_0101 * i));
            for (int i = 0; i < 13; i++) begin
                rd(offs(i), v);
                chk((i == 0 || i == 3 || i == 4) ? "R3 mask" : "R2 store", v,
                    (pats[p] ^ (32'h0101_0101 * i)) & msk(i));
            end
        end
        // R2: low address bits ignored
        wr('h06, 32'h1234_5678); rd('h04, v); chk("R2 lowbits", v, 32'h1234_5678);
        rd('h07, v); chk("R2 lowbits rd", v, 32'h1234_5678);

        // R3: pending/mask widths
        wr('h54, 32'hFFFF_FFFF); rd('h54, v); chk("R3 ipnd", v, 3);
        wr('h58, 32'hFFFF_FFFF); rd('h58, v); chk("R3 spnd", v, 3);
        wr('h5C, 32'hFFFF_FFFF); rd('h5C, v); chk("R3 imsk", v, 7);

        // R4: panel select forced bit
        for (int k = 0; k < 8; k++) begin
            wr('h60, 32'hFFFF_FFF8 | k); rd('h60, v); chk("R4 panel", v, (k & 3) | 4);
        end

        // R7: decoded fields sweep
        for (int m = 0; m < 32; m++) begin
            wr('h00, m); #1;
            chk("R7 enable", {31'b0, disp_en}, m & 1);
            chk("R7 mode", {28'b0, pix_mode}, (m >> 1) & 15);
        end
        for (int m = 0; m < 4; m++) begin
            wr('h10, m << 11); #1;
            chk("R7 fmt565", {31'b0, fmt565}, m & 1);
            chk("R7 byteswap", {31'b0, byte_swap}, (m >> 1) & 1);
        end

        // R8: framebuffer base
        foreach (pats[p]) begin
            wr('h14, pats[p]); #1;
            chk("R8 fb_base", fb_base, (pats[p] << 1) & 32'h7FFF_FFFE);
        end

        // R5: full palette sweep
        for (int i = 0; i < 256; i++) wr('h400 + 2 * i, 32'hDEAD_0000 | ((i * 32'h0107) ^ 16'h5AC3));
        for (int i = 0; i < 256; i++) begin
            rd('h400 + 2 * i, v); chk("R5 palette", v, ((i * 32'h0107) ^ 16'h5AC3) & 32'hFFFF);
        end

        // R6: unmapped reads zero, unmapped writes no effect
        wr('h04, 32'hCAFE_F00D);
        for (int w = 0; w < 256; w++) if (!mapped_word(w)) wr(w * 4, 32'hFFFF_FFFF);
        rd('h04, v); chk("R6 no effect", v, 32'hCAFE_F00D);
        rd('h54, v); chk("R6 no effect ipnd", v, 3);
        for (int w = 0; w < 256; w++) if (!mapped_word(w)) begin rd(w * 4, v); chk("R6 unmapped", v, 0); end

        // R10 / R12: mask-write fold, every mask against every source
        for (int m = 0; m < 8; m++) for (int s = 0; s < 4; s++) begin
            wr('h54, 0); wr('h58, s);
            rd('h54, v); chk("R11 no fold on src write", v, 0);
            wr('h5C, m);
            rd('h54, v); chk("R10 fold", v, s & ~m & 3);
            chk("R12 irq", {31'b0, irq}, ((s & ~m & 3) != 0) ? 1 : 0);
        end

        // R9: frame pulse fold for every mask
        for (int m = 0; m < 8; m++) begin
            wr('h5C, m); wr('h54, 0); wr('h58, 0);
            @(negedge clk); frame_sync = 1'b1;
            @(negedge clk); frame_sync = 1'b0;
            rd('h58, v); chk("R9 src", v, 2);
            rd('h54, v); chk("R9 pend", v, 2 & ~m & 3);
            chk("R12 irq frame", {31'b0, irq}, ((2 & ~m & 3) != 0) ? 1 : 0);
        end

        // R11: replacement semantics
        wr('h58, 1); rd('h58, v); chk("R11 src replace", v, 1);
        wr('h54, 3); rd('h54, v); chk("R11 pend set", v, 3);
        wr('h54, 0); rd('h54, v); chk("R11 pend clear", v, 0);
        chk("R12 irq low", {31'b0, irq}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule